// File: doc/BRIEF.md
# Halving Permute Vector Reducer

This block folds a 64-bit packed vector down to one scalar: the sum of all its lanes. It does not build an adder tree. It keeps a working register and repeats one step. Each step copies the upper half of the live part of the register into a partner value and adds that value lane-wise onto the lower half. The live length halves after every step, so after log2 of the lane count steps one lane remains, and that lane is the sum.

A caller pulses `start` together with a vector and a lane-width code. The block then runs one step per clock and raises `done` for a single cycle with the scalar on `sum_out`. The lane width can be 8, 16 or 32 bits. Only the fixed upper-half-to-lower-half move is supported. No other lane shuffle exists.

Top module: `vec_halving_reducer`

## Requirements
- R1: With `lane_mode` = 2'b00 (8-bit lanes) the block takes 3 steps, and `sum_out` equals the sum of the eight bytes.
- R2: With `lane_mode` = 2'b01 (16-bit lanes) the block takes 2 steps, and `sum_out` equals the sum of the four 16-bit lanes.
- R3: With `lane_mode` = 2'b10 (32-bit lanes) the block takes 1 step, and `sum_out` equals the sum of the two 32-bit lanes. The code 2'b11 behaves exactly like 2'b10.
- R4: Lane sums wrap modulo 2 to the power of the lane width. Bits of `sum_out` above the lane width are zero.
- R5: `done` is high in the cycle that follows n+1 rising edges after the edge that samples `start`, where n is the step count of the mode.
- R6: `done` is high for exactly one cycle per accepted start.
- R7: A `start` that arrives while a reduction is in its step or done phase is ignored. It produces no extra `done`, and it does not change the result of the reduction already running.
- R8: `sum_out` keeps its value from one `done` to the next, whatever happens on `vec_in` and `lane_mode` in between.
- R9: After reset, `done` is 0 and `sum_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a reduction, sampled only when idle |
| vec_in | input | 64 | Packed vector to reduce, lane 0 in the low bits |
| lane_mode | input | 2 | Lane width code: 00 = 8, 01 = 16, 10 or 11 = 32 bits |
| done | output | 1 | One-cycle pulse when `sum_out` holds a new result |
| sum_out | output | 32 | Zero-extended lane sum |

## Verification
The hardest case to reach is a start request that lands while a reduction is still running, including the single done cycle. In that cycle the sequencer is about to return to idle, and a wrong state test would let the request in. The stimulus holds `start` high with a different vector and mode through every step cycle and through the done cycle, then drops it just as the block becomes idle. The bench then checks that the first result came out unchanged and that no second `done` follows.

// File: rtl/hpr_pkg.sv
package hpr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_STEP = 2'b01,
      ST_DONE = 2'b10
   } seq_state_t;

   typedef enum logic [1:0] {
      LANE_8   = 2'b00,
      LANE_16  = 2'b01,
      LANE_32  = 2'b10,
      LANE_32B = 2'b11
   } lane_mode_t;

   // fold the alias code onto the widest lane
   function automatic logic [1:0] lane_log(input logic [1:0] code);
      return (code == LANE_32B) ? 2'(LANE_32) : code;
   endfunction
endpackage

// File: rtl/hpr_ctrl.sv
module hpr_ctrl
   import hpr_pkg::*;
#(
   parameter int STEP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [STEP_W-1:0] n_steps,
   output logic              load,
   output logic              step_en,
   output logic              last,
   output logic [STEP_W-1:0] stage,
   output logic              done
);
   seq_state_t        state;
   logic [STEP_W-1:0] steps_q;

   assign load    = start && (state == ST_IDLE);
   assign step_en = (state == ST_STEP);
   assign last    = step_en && (stage == steps_q - 1'b1);
   assign done    = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         stage   <= '0;
         steps_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state   <= ST_STEP;
               stage   <= '0;
               steps_q <= n_steps;
            end
            ST_STEP: begin
               if (stage == steps_q - 1'b1) state <= ST_DONE;
               else                         stage <= stage + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   step_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STEP) |=> (state != ST_IDLE));
   // R7
   done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (state == ST_IDLE));
   // R5
   idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && start) |=> (step_en && stage == '0));
   // R5
   stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |-> (stage < steps_q));
endmodule

// File: rtl/hpr_half_move.sv
module hpr_half_move #(
   parameter int VEC_W  = 64,
   parameter int STEP_W = 2
) (
   input  logic [VEC_W-1:0]  work,
   input  logic [STEP_W-1:0] stage,
   output logic [VEC_W-1:0]  low_part,
   output logic [VEC_W-1:0]  partner
);
   localparam int SH_W = $clog2(VEC_W) + 1;

   logic [SH_W-1:0] half;

   always_comb begin
      half     = SH_W'(VEC_W >> (int'(stage) + 1));
      partner  = work >> half;
      low_part = work & ({VEC_W{1'b1}} >> (SH_W'(VEC_W) - half));
   end
endmodule

// File: rtl/hpr_lane_add.sv
module hpr_lane_add #(
   parameter int VEC_W    = 64,
   parameter int LANE_MIN = 8
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   input  logic [1:0]       lane_lg,
   output logic [VEC_W-1:0] sum
);
   localparam int NSEG = VEC_W / LANE_MIN;

   logic [NSEG:0]   carry;
   logic [NSEG-1:0] seg_brk;
   logic [1:0]      msk;

   assign carry[0] = 1'b0;
   assign msk = (lane_lg == 2'd0) ? 2'b00 : (lane_lg == 2'd1) ? 2'b01 : 2'b11;

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam logic [31:0] GI = g;
      logic [LANE_MIN:0] part;
      assign seg_brk[g] = ((GI[1:0] & msk) == 2'b00);
      assign part = {1'b0, a[g*LANE_MIN +: LANE_MIN]}
                  + {1'b0, b[g*LANE_MIN +: LANE_MIN]}
                  + {{LANE_MIN{1'b0}}, (seg_brk[g] ? 1'b0 : carry[g])};
      assign sum[g*LANE_MIN +: LANE_MIN] = part[LANE_MIN-1:0];
      assign carry[g+1] = part[LANE_MIN];
   end
endmodule

// File: rtl/vec_halving_reducer.sv
module vec_halving_reducer
   import hpr_pkg::*;
#(
   parameter int VEC_W    = 64,
   parameter int LANE_MIN = 8,
   parameter int RES_W    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [63:0]      vec_in,
   input  logic [1:0]       lane_mode,
   output logic             done,
   output logic [31:0]      sum_out
);
   localparam int TOP_STEPS = $clog2(VEC_W / LANE_MIN);
   localparam int STEP_W    = $clog2(TOP_STEPS + 1);

   if (VEC_W != 64 || RES_W != 32) begin : g_bad_port
      $error("port widths are fixed at 64 in, 32 out");
   end
   if ((VEC_W & (VEC_W - 1)) != 0 || VEC_W < 8 * LANE_MIN) begin : g_bad_vec
      $error("VEC_W must be a power of two holding two widest lanes");
   end
   if (RES_W < 4 * LANE_MIN) begin : g_bad_res
      $error("RES_W must hold the widest lane");
   end

   logic [VEC_W-1:0]  work, low_part, partner, step_sum;
   logic [RES_W-1:0]  res_q;
   logic [1:0]        lg_in, lg_q;
   logic [STEP_W-1:0] n_steps, stage;
   logic              load, step_en, last;

   assign lg_in   = lane_log(lane_mode);
   assign n_steps = STEP_W'(TOP_STEPS) - STEP_W'(lg_in);

   hpr_ctrl #(.STEP_W(STEP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .n_steps(n_steps),
      .load(load), .step_en(step_en), .last(last), .stage(stage), .done(done)
   );

   hpr_half_move #(.VEC_W(VEC_W), .STEP_W(STEP_W)) u_move (
      .work(work), .stage(stage), .low_part(low_part), .partner(partner)
   );

   hpr_lane_add #(.VEC_W(VEC_W), .LANE_MIN(LANE_MIN)) u_add (
      .a(low_part), .b(partner), .lane_lg(lg_q), .sum(step_sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work  <= '0;
         lg_q  <= '0;
         res_q <= '0;
      end else begin
         if (load) begin
            work <= vec_in;
            lg_q <= lg_in;
         end else if (step_en) begin
            work <= step_sum;
         end
         if (last) res_q <= step_sum[RES_W-1:0];
      end
   end

   assign sum_out = res_q;

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sum_out) |-> done);
   // R4
   upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> ((work >> (VEC_W >> (int'($past(stage)) + 1))) == '0));
   // R4
   result_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((sum_out >> (LANE_MIN << lg_q)) == '0));
endmodule

// File: tb/vec_halving_reducer_bench.sv
module vec_halving_reducer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] vec_in = '0;
   logic [1:0]  lane_mode = 2'b00;
   logic        done;
   logic [31:0] sum_out;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   vec_halving_reducer u_vec_halving_reducer (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec_in),
      .lane_mode(lane_mode), .done(done), .sum_out(sum_out)
   );

   function automatic logic [31:0] ref_sum(input logic [63:0] v, input int w);
      logic [63:0] m, acc;
      m   = (64'd1 << w) - 64'd1;
      acc = '0;
      for (int i = 0; i < 64 / w; i++) acc = (acc + ((v >> (i * w)) & m)) & m;
      return acc[31:0];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_reduce(input string req, input logic [63:0] v,
                             input logic [1:0] mode, input int w, input int steps);
      int cnt;
      @(negedge clk);
      vec_in = v; lane_mode = mode; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (!done && cnt < 20) begin
         @(negedge clk);
         cnt++;
      end
      check({req, " latency (R5)"}, 64'(cnt), 64'(steps + 1));
      check({req, " sum"}, {32'd0, sum_out}, {32'd0, ref_sum(v, w)});
      @(negedge clk);
      check("R6 done pulse width", {63'd0, done}, 64'd0);
   endtask

   task automatic test_reset();
      check("R9 done after reset", {63'd0, done}, 64'd0);
      check("R9 sum after reset", {32'd0, sum_out}, 64'd0);
   endtask

   task automatic test_modes();
      run_reduce("R1 bytes", 64'h0807_0605_0403_0201, 2'b00, 8, 3);
      run_reduce("R1 bytes mixed", 64'h1020_3040_0A0B_0C0D, 2'b00, 8, 3);
      run_reduce("R2 halfwords", 64'h0004_0003_0002_0001, 2'b01, 16, 2);
      run_reduce("R2 halfwords mixed", 64'h1234_0F0F_00FF_4321, 2'b01, 16, 2);
      run_reduce("R3 words", 64'h1111_1111_2222_2222, 2'b10, 32, 1);
      run_reduce("R3 alias code", 64'h0000_0005_0000_0007, 2'b11, 32, 1);
   endtask

   task automatic test_wrap();
      run_reduce("R4 byte wrap", 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 8, 3);
      run_reduce("R4 half wrap", 64'hFFFF_8000_8000_0001, 2'b01, 16, 2);
      run_reduce("R4 word wrap", 64'hFFFF_FFFF_0000_0003, 2'b10, 32, 1);
   endtask

   task automatic test_busy_start();
      logic [63:0] va;
      bit seen;
      va = 64'h0102_0304_0506_0708;
      @(negedge clk);
      vec_in = va; lane_mode = 2'b00; start = 1'b1;
      for (int c = 1; c <= 4; c++) begin
         @(negedge clk);
         vec_in = 64'hDEAD_BEEF_CAFE_F00D; lane_mode = 2'b10; start = 1'b1;
         if (c == 4) begin
            check("R7 done during busy start", {63'd0, done}, 64'd1);
            check("R7 first result kept", {32'd0, sum_out}, {32'd0, ref_sum(va, 8)});
         end
      end
      @(negedge clk);
      start = 1'b0;
      seen = 1'b0;
      for (int c = 0; c < 6; c++) begin
         if (done) seen = 1'b1;
         @(negedge clk);
      end
      check("R7 no extra done", {63'd0, seen}, 64'd0);
   endtask

   task automatic test_hold();
      logic [31:0] held;
      held = sum_out;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         vec_in = ~vec_in; lane_mode = lane_mode + 2'd1;
      end
      check("R8 result held", {32'd0, sum_out}, {32'd0, held});
   endtask

   initial begin
      #(4 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1;
      test_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_modes();
      test_wrap();
      test_busy_start();
      test_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule